// File: doc/BRIEF.md
# Byte-Lane Host Bus Slave with Wait Arbitration

This block lets a host processor read and write a small shared word memory that a display refresh engine also reads. The host side runs on its own bus clock, which may be fully asynchronous to the core clock that owns the memory. An access is a chip select held low together with either the read strobe or the write strobe. An active-low high-byte enable and address bit 0 pick which byte lanes of the 16-bit data bus take part.

The slave captures the access in the host clock domain and hands it to the core domain through a four-phase request/acknowledge handshake. Each direction crosses through a two-stage synchroniser. The wait output holds the host off until the core has finished the access. A refresh read in the same core cycle always takes the memory port first, so the host cycle is stretched for as long as refresh traffic continues. An 8-bit host mirrors its data byte on both halves of the bus and drives the high-byte enable as the inverse of address bit 0. It can therefore use the block without any glue logic.

Host states: `H_IDLE` (no access in progress; a new access is captured here), `H_XFER` (request raised, waiting for the acknowledge), `H_HOLD` (request dropped, waiting for the acknowledge to fall), `H_PARK` (done, waiting for the strobes to be released). Host transitions: `H_IDLE`→`H_XFER` on a new access, `H_XFER`→`H_HOLD` when the synchronised acknowledge is seen, `H_HOLD`→`H_IDLE` when the acknowledge has fallen and the strobes have been released, `H_HOLD`→`H_PARK` when the acknowledge has fallen but the strobes are still held, and `H_PARK`→`H_IDLE` on release. Core states: `C_IDLE` (waits for a request that refresh does not block), `C_ACK` (holds the acknowledge until the request falls). Core transitions: `C_IDLE`→`C_ACK` when the host is granted the memory port, and `C_ACK`→`C_IDLE` when the synchronised request falls.

Top module: `hbus_slave`

## Requirements
- R1: After reset, wait_n is 1, host_dout is 0 and ref_vld is 0.
- R2: A write (cs_n=0, wr_n=0) updates the memory word at index addr[IDX_W:1]. The low byte is written from host_din[7:0] when addr[0]=0. The high byte is written from host_din[15:8] when hbe_n=0. A byte whose lane is not enabled keeps its old value.
- R3: A read (cs_n=0, rd_n=0) drives the stored byte on each enabled lane of host_dout, using the same lane rule as R2, and drives 0 on each lane that is not enabled. The data is valid once wait_n is 1.
- R4: An 8-bit host that puts its byte on both halves of host_din and sets hbe_n = ~addr[0] reaches the upper byte of a word at odd addresses and the lower byte at even addresses.
- R5: wait_n is 0 in the same host cycle in which a new access begins (combinationally from the strobes). It stays 0 until the access has completed.
- R6: Every access completes (wait_n returns to 1) within a bounded number of cycles when there is no refresh traffic.
- R7: When a host request and a refresh request meet in the same core cycle, refresh gets the memory. While ref_req is held high, a host access does not complete. It completes after ref_req falls.
- R8: A refresh request is served every core cycle. ref_vld is 1 one core cycle after ref_req, and ref_dout then holds the word at ref_addr.
- R9: Each assertion of chip select and strobe is captured once. While the strobes stay held after completion, changes on host_din are ignored, no second write happens, and wait_n stays 1.
- R10: host_dout is 0 whenever cs_n or rd_n is 1.
- R11: The host request stays high until the synchronised acknowledge arrives, and the core raises its acknowledge only while the synchronised request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host bus clock |
| host_rst_n | input | 1 | Host domain reset, active low |
| core_clk | input | 1 | Core clock that owns the memory |
| core_rst_n | input | 1 | Core domain reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| hbe_n | input | 1 | High-byte lane enable, active low |
| addr | input | ADDR_W (17) | Host byte address; bit 0 enables the low lane when 0 |
| host_din | input | 16 | Write data from the host |
| host_dout | output | 16 | Read data to the host, zero when not reading |
| wait_n | output | 1 | Wait, active low, held while an access is unfinished |
| ref_req | input | 1 | Refresh read request (core domain) |
| ref_addr | input | IDX_W (6) | Refresh word index |
| ref_vld | output | 1 | Refresh data valid |
| ref_dout | output | 16 | Refresh read data |

## Verification
The whole memory is first filled with byte-wide writes at every byte address, each with its own value. It is then read back with word-wide reads. Any swap of lanes, or any write that touches the lane not enabled, shows up as a wrong byte in the assembled word. After that, every word is overwritten word-wide and read back byte by byte with an 8-bit host pattern. This separates upper-lane from lower-lane steering and confirms that the lane not enabled reads as zero. Refresh reads at chosen indices check the refresh port. A long stretch with refresh held high shows that refresh wins arbitration and that wait_n is stretched. A write held past completion while its data changes shows that the access is captured only once.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
    typedef enum logic [1:0] {H_IDLE, H_XFER, H_HOLD, H_PARK} hstate_e;
    typedef enum logic       {C_IDLE, C_ACK} cstate_e;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;
endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbs_host_fsm.sv
module hbs_host_fsm
    import hbs_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int IDX_W  = 6
) (
    input  logic              hclk,
    input  logic              hrst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              hbe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] din,
    input  logic              ack_s,
    input  logic [WORD_W-1:0] core_rdata,
    output logic [WORD_W-1:0] dout,
    output logic              wait_n,
    output logic              req,
    output hstate_e           hstate,
    output logic [IDX_W-1:0]  cap_idx,
    output logic [LANES-1:0]  cap_be,
    output logic              cap_wr,
    output logic [WORD_W-1:0] cap_wdata
);
    hstate_e           nxt;
    logic              access;
    logic              released;
    logic              rd_valid;
    logic [WORD_W-1:0] rdata_q;
    logic              unused_hi;

    assign access    = !cs_n && (!rd_n || !wr_n);
    assign unused_hi = ^addr[ADDR_W-1:IDX_W+1];

    // state register and registered request
    always_ff @(posedge hclk or negedge hrst_n) begin
        if (!hrst_n) begin
            hstate <= H_IDLE;
            req    <= 1'b0;
        end else begin
            hstate <= nxt;
            req    <= (nxt == H_XFER);
        end
    end

    // captured access, release tracking, returned read data
    always_ff @(posedge hclk or negedge hrst_n) begin
        if (!hrst_n) begin
            cap_idx   <= '0;
            cap_be    <= '0;
            cap_wr    <= 1'b0;
            cap_wdata <= '0;
            released  <= 1'b0;
            rdata_q   <= '0;
        end else begin
            if (hstate == H_IDLE && access) begin
                cap_idx   <= addr[IDX_W:1];
                cap_be    <= {~hbe_n, ~addr[0]};
                cap_wr    <= !wr_n;
                cap_wdata <= din;
            end
            if (hstate == H_HOLD) begin
                if (!access) released <= 1'b1;
            end else begin
                released <= 1'b0;
            end
            if (hstate == H_XFER && ack_s) rdata_q <= core_rdata;
        end
    end

    // next-state
    always_comb begin
        nxt = hstate;
        unique case (hstate)
            H_IDLE: if (access) nxt = H_XFER;
            H_XFER: if (ack_s)  nxt = H_HOLD;
            H_HOLD: if (!ack_s) nxt = (released || !access) ? H_IDLE : H_PARK;
            H_PARK: if (!access) nxt = H_IDLE;
            default: nxt = H_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wait_n   = !(access && (hstate == H_IDLE || hstate == H_XFER ||
                                (hstate == H_HOLD && released)));
        rd_valid = !cs_n && !rd_n && !cap_wr &&
                   ((hstate == H_HOLD && !released) || hstate == H_PARK);
        for (int l = 0; l < LANES; l++) begin
            dout[l*LANE_W +: LANE_W] = (rd_valid && cap_be[l]) ?
                                       rdata_q[l*LANE_W +: LANE_W] : '0;
        end
    end
endmodule

// File: rtl/hbs_core.sv
module hbs_core
    import hbs_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic              cclk,
    input  logic              crst_n,
    input  logic              req_s,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [LANES-1:0]  cap_be,
    input  logic              cap_wr,
    input  logic [WORD_W-1:0] cap_wdata,
    input  logic              ref_req,
    input  logic [IDX_W-1:0]  ref_addr,
    output logic              ack,
    output logic [WORD_W-1:0] rdata,
    output logic              ref_vld,
    output logic [WORD_W-1:0] ref_dout,
    output logic              host_go
);
    localparam int DEPTH = 1 << IDX_W;

    cstate_e           cstate;
    cstate_e           cnxt;
    logic [WORD_W-1:0] mem [DEPTH];

    // state register and registered acknowledge
    always_ff @(posedge cclk or negedge crst_n) begin
        if (!crst_n) begin
            cstate <= C_IDLE;
            ack    <= 1'b0;
        end else begin
            cstate <= cnxt;
            ack    <= (cnxt == C_ACK);
        end
    end

    // shared memory: refresh has priority on the single port
    always_ff @(posedge cclk) begin
        if (host_go && cap_wr) begin
            for (int l = 0; l < LANES; l++) begin
                if (cap_be[l]) mem[cap_idx][l*LANE_W +: LANE_W] <= cap_wdata[l*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge cclk or negedge crst_n) begin
        if (!crst_n) begin
            rdata    <= '0;
            ref_dout <= '0;
            ref_vld  <= 1'b0;
        end else begin
            ref_vld <= ref_req;
            if (ref_req)              ref_dout <= mem[ref_addr];
            if (host_go && !cap_wr)   rdata    <= mem[cap_idx];
        end
    end

    always_comb begin
        host_go = (cstate == C_IDLE) && req_s && !ref_req;
        cnxt    = cstate;
        unique case (cstate)
            C_IDLE: if (host_go) cnxt = C_ACK;
            C_ACK:  if (!req_s)  cnxt = C_IDLE;
            default: cnxt = C_IDLE;
        endcase
    end
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
    import hbs_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int IDX_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              host_clk,
    input  logic              host_rst_n,
    input  logic              core_clk,
    input  logic              core_rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              hbe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       host_din,
    output logic [15:0]       host_dout,
    output logic              wait_n,
    input  logic              ref_req,
    input  logic [IDX_W-1:0]  ref_addr,
    output logic              ref_vld,
    output logic [15:0]       ref_dout
);
    logic              req;
    logic              req_s;
    logic              ack;
    logic              ack_s;
    logic              host_go;
    hstate_e           hstate;
    logic [IDX_W-1:0]  cap_idx;
    logic [LANES-1:0]  cap_be;
    logic              cap_wr;
    logic [WORD_W-1:0] cap_wdata;
    logic [WORD_W-1:0] core_rdata;

    hbs_host_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_host (
        .hclk(host_clk), .hrst_n(host_rst_n),
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .hbe_n(hbe_n),
        .addr(addr), .din(host_din),
        .ack_s(ack_s), .core_rdata(core_rdata),
        .dout(host_dout), .wait_n(wait_n), .req(req), .hstate(hstate),
        .cap_idx(cap_idx), .cap_be(cap_be), .cap_wr(cap_wr), .cap_wdata(cap_wdata)
    );

    hbs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(core_clk), .rst_n(core_rst_n), .d(req), .q(req_s)
    );

    hbs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(host_clk), .rst_n(host_rst_n), .d(ack), .q(ack_s)
    );

    hbs_core #(.IDX_W(IDX_W)) u_core (
        .cclk(core_clk), .crst_n(core_rst_n),
        .req_s(req_s), .cap_idx(cap_idx), .cap_be(cap_be),
        .cap_wr(cap_wr), .cap_wdata(cap_wdata),
        .ref_req(ref_req), .ref_addr(ref_addr),
        .ack(ack), .rdata(core_rdata),
        .ref_vld(ref_vld), .ref_dout(ref_dout), .host_go(host_go)
    );
endmodule

// File: rtl/hbus_slave_chk.sv
module hbus_slave_chk
    import hbs_pkg::*;
(
    input logic        host_clk,
    input logic        host_rst_n,
    input logic        core_clk,
    input logic        core_rst_n,
    input logic        cs_n,
    input logic        rd_n,
    input logic        wr_n,
    input logic [15:0] host_dout,
    input logic        wait_n,
    input logic        req,
    input logic        ack_s,
    input logic        ack,
    input logic        req_s,
    input logic        host_go,
    input logic        ref_req,
    input logic        ref_vld,
    input hstate_e     hstate,
    input logic [15:0] cap_wdata
);
    AST_DOUT_QUIET: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        (cs_n || rd_n) |-> (host_dout == 16'h0000)); // R10

    AST_WAIT_IN_XFER: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        (hstate == H_XFER && !cs_n && (!rd_n || !wr_n)) |-> !wait_n); // R5

    AST_REQ_HELD: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        (req && !ack_s) |=> req); // R11

    AST_ACK_NEEDS_REQ: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        $rose(ack) |-> req_s); // R11

    AST_REF_WINS: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        ref_req |-> !host_go); // R7

    AST_REF_VALID: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        ref_req |=> ref_vld); // R8

    AST_NO_RECAPTURE: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        (hstate == H_PARK) |=> $stable(cap_wdata)); // R9
endmodule

bind hbus_slave hbus_slave_chk u_chk (
    .host_clk(host_clk), .host_rst_n(host_rst_n),
    .core_clk(core_clk), .core_rst_n(core_rst_n),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .host_dout(host_dout), .wait_n(wait_n),
    .req(req), .ack_s(ack_s), .ack(ack), .req_s(req_s),
    .host_go(host_go), .ref_req(ref_req), .ref_vld(ref_vld),
    .hstate(hstate), .cap_wdata(cap_wdata)
);

// File: tb/sim_hbus_slave.sv
module sim_hbus_slave;
    localparam int HCLK_PERIOD = 10;
    localparam int CCLK_PERIOD = 7;
    localparam int IDX_W       = 6;
    localparam int NBYTES      = 2 << IDX_W;
    localparam int NWORDS      = 1 << IDX_W;

    logic        host_clk = 0, core_clk = 0;
    logic        host_rst_n = 0, core_rst_n = 0;
    logic        cs_n = 1, rd_n = 1, wr_n = 1, hbe_n = 1;
    logic [16:0] addr = '0;
    logic [15:0] host_din = '0;
    logic [15:0] host_dout;
    logic        wait_n;
    logic        ref_req = 0;
    logic [IDX_W-1:0] ref_addr = '0;
    logic        ref_vld;
    logic [15:0] ref_dout;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [NBYTES];

    always #(HCLK_PERIOD/2) host_clk = ~host_clk;
    always #(CCLK_PERIOD/2) core_clk = ~core_clk;

    hbus_slave #(.ADDR_W(17), .IDX_W(IDX_W), .SYNC_STAGES(2)) u0 (
        .host_clk(host_clk), .host_rst_n(host_rst_n),
        .core_clk(core_clk), .core_rst_n(core_rst_n),
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .hbe_n(hbe_n),
        .addr(addr), .host_din(host_din), .host_dout(host_dout),
        .wait_n(wait_n), .ref_req(ref_req), .ref_addr(ref_addr),
        .ref_vld(ref_vld), .ref_dout(ref_dout)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] word_of(input int w);
        return {model[2*w+1], model[2*w]};
    endfunction

    // one host access; returns the read data seen once wait_n is released
    task automatic access(input logic [16:0] a, input logic [15:0] d, input bit wr,
                          input bit be_n, output logic [15:0] rdat);
        int n;
        @(negedge host_clk);
        addr = a; host_din = d; hbe_n = be_n; cs_n = 0;
        if (wr) wr_n = 0; else rd_n = 0;
        #1;
        chk(wait_n == 1'b0, "R5 wait at access start", {15'd0, wait_n}, 16'd0);
        n = 0;
        while (!wait_n && n < 400) begin
            @(negedge host_clk);
            n++;
        end
        if (!wait_n) chk(1'b0, "R6 access timeout", {15'd0, wait_n}, 16'd1);
        rdat = host_dout;
        @(negedge host_clk);
        cs_n = 1; rd_n = 1; wr_n = 1;
        #1;
        if (!wr) chk(host_dout == 16'h0, "R10 dout idle after read", host_dout, 16'h0);
    endtask

    initial begin
        #(HCLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] r;
        int n;
        repeat (4) @(negedge host_clk);
        #1;
        chk(wait_n == 1'b1, "R1 wait_n in reset", {15'd0, wait_n}, 16'd1);
        chk(host_dout == 16'h0, "R1 dout in reset", host_dout, 16'h0);
        chk(ref_vld == 1'b0, "R1 ref_vld in reset", {15'd0, ref_vld}, 16'd0);
        host_rst_n = 1; core_rst_n = 1;
        repeat (3) @(negedge host_clk);
        chk(wait_n == 1'b1, "R1 wait_n after reset", {15'd0, wait_n}, 16'd1);

        // R2/R4: 8-bit host writes every byte, byte mirrored on both lanes
        for (int a = 0; a < NBYTES; a++) begin
            logic [7:0] b;
            b = 8'(a * 37 + 11);
            access(17'(a), {b, b}, 1'b1, ~a[0], r);
            model[a] = b;
        end
        // R3: word reads assemble both lanes
        for (int w = 0; w < NWORDS; w++) begin
            access(17'(2*w), 16'h0, 1'b0, 1'b0, r);
            chk(r == word_of(w), "R3 R2 word read after byte writes", r, word_of(w));
        end
        // R2: word writes
        for (int w = 0; w < NWORDS; w++) begin
            logic [15:0] v;
            v = 16'((w * 1237) ^ 16'hA55A);
            access(17'(2*w), v, 1'b1, 1'b0, r);
            model[2*w] = v[7:0];
            model[2*w+1] = v[15:8];
        end
        // R4: 8-bit reads, enabled lane only, other lane zero
        for (int a = 0; a < NBYTES; a++) begin
            logic [15:0] e;
            e = a[0] ? {model[a], 8'h00} : {8'h00, model[a]};
            access(17'(a), 16'h0, 1'b0, ~a[0], r);
            chk(r == e, "R4 R3 byte read lane", r, e);
        end
        // R2: high-lane-only write leaves low byte
        access(17'd21, 16'hC3C3, 1'b1, 1'b0, r);
        model[21] = 8'hC3;
        access(17'd20, 16'h0, 1'b0, 1'b0, r);
        chk(r == word_of(10), "R2 untouched low lane", r, word_of(10));

        // R8: refresh reads
        for (int w = 0; w < NWORDS; w += 7) begin
            @(negedge core_clk);
            ref_req = 1; ref_addr = IDX_W'(w);
            @(negedge core_clk);
            ref_req = 0;
            chk(ref_vld == 1'b1, "R8 ref_vld", {15'd0, ref_vld}, 16'd1);
            chk(ref_dout == word_of(w), "R8 ref data", ref_dout, word_of(w));
        end

        // R7: refresh held blocks host access
        @(negedge core_clk);
        ref_req = 1; ref_addr = '0;
        @(negedge host_clk);
        addr = 17'd6; host_din = 16'h1357; hbe_n = 0; cs_n = 0; wr_n = 0;
        repeat (40) @(negedge host_clk);
        chk(wait_n == 1'b0, "R7 host stalled by refresh", {15'd0, wait_n}, 16'd0);
        @(negedge core_clk);
        ref_req = 0;
        n = 0;
        while (!wait_n && n < 400) begin
            @(negedge host_clk);
            n++;
        end
        chk(wait_n == 1'b1, "R7 host completes after refresh", {15'd0, wait_n}, 16'd1);
        @(negedge host_clk);
        cs_n = 1; wr_n = 1;
        model[6] = 8'h57; model[7] = 8'h13;
        access(17'd6, 16'h0, 1'b0, 1'b0, r);
        chk(r == 16'h1357, "R7 stalled write landed", r, 16'h1357);

        // R9: held strobe after completion, data change ignored
        @(negedge host_clk);
        addr = 17'd10; host_din = 16'hBEEF; hbe_n = 0; cs_n = 0; wr_n = 0;
        n = 0;
        @(negedge host_clk);
        while (!wait_n && n < 400) begin
            @(negedge host_clk);
            n++;
        end
        host_din = 16'h0BAD;
        repeat (30) @(negedge host_clk);
        chk(wait_n == 1'b1, "R9 wait stays released while held", {15'd0, wait_n}, 16'd1);
        cs_n = 1; wr_n = 1;
        access(17'd10, 16'h0, 1'b0, 1'b0, r);
        chk(r == 16'hBEEF, "R9 single capture", r, 16'hBEEF);

        // R10: read strobe lifted while chip select stays low
        @(negedge host_clk);
        addr = 17'd10; hbe_n = 0; cs_n = 0; rd_n = 0;
        n = 0;
        @(negedge host_clk);
        while (!wait_n && n < 400) begin
            @(negedge host_clk);
            n++;
        end
        chk(host_dout == 16'hBEEF, "R3 read valid when held", host_dout, 16'hBEEF);
        rd_n = 1;
        #1;
        chk(host_dout == 16'h0, "R10 dout zero with rd_n high", host_dout, 16'h0);
        @(negedge host_clk);
        cs_n = 1;
        repeat (10) @(negedge host_clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule